// File: doc/BRIEF.md
# SPI Board Control Register Bank

This block is a serial peripheral slave that gives a host processor access to a small set of 8-bit board registers. It drives LED lines, card power enables, several reset lines, two optical-module control bytes and a power-management bus control byte. It also reports push-button and DIP-switch levels, three power-good bytes and a bus-master selection byte. Every SPI pin is oversampled by the block's own system clock through a two-stage synchronizer, so the serial clock has to run well below the system clock.

Each chip-select frame carries exactly one access: an address byte, then a data byte, both MSB first. Bit 0 of the address byte gives the direction and bits 7..1 pick the register, so every register sits at an even address. Switch changes are latched into sticky flag bits. The host clears them by writing ones to the flag register, and a level interrupt output stays high while any flag is set.

Top module: `spi_board_ctrl`

## Requirements
- R1: The bus runs in mode 3: MOSI is sampled on rising SCLK edges. Read data goes out on MISO MSB first, starting at the first falling SCLK edge after the eighth rising edge, and shifts on each later falling edge.
- R2: A frame holds one 8-bit address and one 8-bit data byte. Rising edges beyond the sixteenth are ignored, there is no auto-increment, and the next frame decodes a fresh address.
- R3: Address bit 0 set to 1 reads the register selected by bits 7..1. Bit 0 cleared to 0 writes that register on the sixteenth rising edge.
- R4: Address 0x00 reads the VERSION parameter (default 0x5A). A write to 0x00 changes nothing.
- R5: The LED register at 0x02 is read/write over all 8 bits. Its bits 7..4 drive led_o[3:0].
- R6: Register 0x04 reads the synchronized sw_i inputs. Writes to it are ignored.
- R7: Register 0x06 holds one flag per sw_i bit. A flag sets when its synchronized input changes. Writing 0x06 clears the flags written as 1, and a change in the same cycle wins over the clear. irq_o is high while any flag is set.
- R8: Registers 0x08, 0x0A and 0x0C read pgood0_i, pgood1_i and pgood2_i, and 0x18 reads mstsel_i. Writes to these four registers are ignored.
- R9: The control registers reset to 0x00, are read/write, and drive their outputs. The mapping is 0x0E card_pwr_o, 0x10 cpu_rst_o, 0x12 periph_rst_o, 0x14 sfp_a_o, 0x16 sfp_b_o, 0x1A warm_rst_o, 0x1C warm_key_o and 0x1E pmbus_o.
- R10: Raising cs_n before the sixteenth rising edge aborts the frame without a write. MISO is 0 while cs_n is high.
- R11: Addresses 0x20 and above read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, idles high |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| sw_i | input | 8 | Push-button and DIP-switch levels |
| pgood0_i | input | 8 | Power-good group 0 |
| pgood1_i | input | 8 | Power-good group 1 |
| pgood2_i | input | 8 | Power-good group 2 |
| mstsel_i | input | 8 | Bus-master selection status |
| led_o | output | 4 | LED drive (LED register bits 7..4) |
| card_pwr_o | output | 8 | Card and PCIe power enables |
| cpu_rst_o | output | 8 | Processor reset control |
| periph_rst_o | output | 8 | Peripheral reset control |
| sfp_a_o | output | 8 | Optical module A control |
| sfp_b_o | output | 8 | Optical module B control |
| warm_rst_o | output | 8 | Warm reset control |
| warm_key_o | output | 8 | Warm reset key |
| pmbus_o | output | 8 | Power-management bus control |
| irq_o | output | 1 | High while any switch flag is set |

## Verification
The hardest case to reach is a switch change that lands in the same system-clock cycle as a flag-clear write, because the change has to win. The bench drives the new sw_i value at the same instant it raises SCLK for the sixteenth time. Both signals pass through identical synchronizer stages, so the change detection and the write commit fall in the same cycle. The bench then reads the flag back and expects the freshly changed bit to survive a clear-all write.

// File: rtl/spi_board_ctrl.sv
module spi_board_ctrl #(
  parameter logic [7:0] VERSION = 8'h5A,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  input  logic [7:0] sw_i,
  input  logic [7:0] pgood0_i,
  input  logic [7:0] pgood1_i,
  input  logic [7:0] pgood2_i,
  input  logic [7:0] mstsel_i,
  output logic [3:0] led_o,
  output logic [7:0] card_pwr_o,
  output logic [7:0] cpu_rst_o,
  output logic [7:0] periph_rst_o,
  output logic [7:0] sfp_a_o,
  output logic [7:0] sfp_b_o,
  output logic [7:0] warm_rst_o,
  output logic [7:0] warm_key_o,
  output logic [7:0] pmbus_o,
  output logic       irq_o
);
  localparam int W = 8;
  localparam int N = 3 + 5 * W;
  localparam logic [N-1:0] SYNC_RST = {2'b11, {(N-2){1'b0}}};
  localparam logic [4:0] FRAME_BITS = 5'd16;

  logic [N-1:0] raw;
  logic [N-1:0] sync_q [SYNC];
  logic [N-1:0] s;
  assign raw = {sclk, cs_n, mosi, mstsel_i, pgood2_i, pgood1_i, pgood0_i, sw_i};
  assign s = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  logic         sclk_s, cs_s, mosi_s;
  logic [W-1:0] msel_s, pg2_s, pg1_s, pg0_s, sw_s;
  assign sclk_s = s[N-1];
  assign cs_s   = s[N-2];
  assign mosi_s = s[N-3];
  assign msel_s = s[5*W-1:4*W];
  assign pg2_s  = s[4*W-1:3*W];
  assign pg1_s  = s[3*W-1:2*W];
  assign pg0_s  = s[2*W-1:W];
  assign sw_s   = s[W-1:0];

  logic         sclk_q;
  logic [W-1:0] sw_q;
  logic         rise, fall;
  assign rise = !cs_s && sclk_s && !sclk_q;
  assign fall = !cs_s && !sclk_s && sclk_q;

  logic [4:0]   cnt;
  logic [W-2:0] sh_in;
  logic [W-1:0] addr, tx, rdata, byte_in;
  logic         wr_en;
  logic [6:0]   wr_idx;
  assign byte_in = {sh_in, mosi_s};
  assign wr_idx  = addr[7:1];
  assign wr_en   = rise && cnt == 5'd15 && !addr[0];

  logic [W-1:0] led_q, flags;
  logic [W-1:0] card_q, cpu_q, per_q, sfpa_q, sfpb_q, wrst_q, wkey_q, pmb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sw_q   <= '0;
      cnt    <= '0;
      sh_in  <= '0;
      addr   <= '0;
      tx     <= '0;
    end else begin
      sclk_q <= sclk_s;
      sw_q   <= sw_s;
      if (cs_s) begin
        cnt <= '0;
        tx  <= '0;
      end else begin
        if (rise && cnt < FRAME_BITS) begin
          sh_in <= byte_in[W-2:0];
          cnt   <= cnt + 5'd1;
          if (cnt == 5'd7) addr <= byte_in;
        end
        if (fall) begin
          if (cnt == 5'd8) tx <= rdata;
          else if (cnt > 5'd8) tx <= {tx[W-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[0]) begin
      case (wr_idx)
        7'd0:  rdata = VERSION;
        7'd1:  rdata = led_q;
        7'd2:  rdata = sw_s;
        7'd3:  rdata = flags;
        7'd4:  rdata = pg0_s;
        7'd5:  rdata = pg1_s;
        7'd6:  rdata = pg2_s;
        7'd7:  rdata = card_q;
        7'd8:  rdata = cpu_q;
        7'd9:  rdata = per_q;
        7'd10: rdata = sfpa_q;
        7'd11: rdata = sfpb_q;
        7'd12: rdata = msel_s;
        7'd13: rdata = wrst_q;
        7'd14: rdata = wkey_q;
        7'd15: rdata = pmb_q;
        default: rdata = '0;
      endcase
    end
  end

  logic [W-1:0] clr;
  assign clr = (wr_en && wr_idx == 7'd3) ? byte_in : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      flags  <= '0;
      card_q <= '0;
      cpu_q  <= '0;
      per_q  <= '0;
      sfpa_q <= '0;
      sfpb_q <= '0;
      wrst_q <= '0;
      wkey_q <= '0;
      pmb_q  <= '0;
    end else begin
      flags <= (flags & ~clr) | (sw_s ^ sw_q);
      if (wr_en) begin
        case (wr_idx)
          7'd1:  led_q  <= byte_in;
          7'd7:  card_q <= byte_in;
          7'd8:  cpu_q  <= byte_in;
          7'd9:  per_q  <= byte_in;
          7'd10: sfpa_q <= byte_in;
          7'd11: sfpb_q <= byte_in;
          7'd13: wrst_q <= byte_in;
          7'd14: wkey_q <= byte_in;
          7'd15: pmb_q  <= byte_in;
          default: ;
        endcase
      end
    end
  end

  assign miso         = tx[W-1];
  assign led_o        = led_q[7:4];
  assign card_pwr_o   = card_q;
  assign cpu_rst_o    = cpu_q;
  assign periph_rst_o = per_q;
  assign sfp_a_o      = sfpa_q;
  assign sfp_b_o      = sfpb_q;
  assign warm_rst_o   = wrst_q;
  assign warm_key_o   = wkey_q;
  assign pmbus_o      = pmb_q;
  assign irq_o        = |flags;

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FRAME_BITS);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == 5'd0 && !miso));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_s != sw_q) |=> ((flags & $past(sw_s ^ sw_q)) == $past(sw_s ^ sw_q)));

  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({led_q, card_q, cpu_q, per_q, sfpa_q, sfpb_q, wrst_q, wkey_q, pmb_q}));
endmodule

// File: tb/test_spi_board_ctrl.sv
`timescale 1ns/1ps
module test_spi_board_ctrl;
  localparam int HP = 6;
  localparam logic [7:0] VER = 8'h5A;

  logic clk = 0, rst_n = 0, sclk = 1, cs_n = 1, mosi = 0;
  logic miso, irq_o;
  logic [7:0] sw_i = 0, pgood0_i = 0, pgood1_i = 0, pgood2_i = 0, mstsel_i = 0;
  logic [3:0] led_o;
  logic [7:0] card_pwr_o, cpu_rst_o, periph_rst_o, sfp_a_o, sfp_b_o;
  logic [7:0] warm_rst_o, warm_key_o, pmbus_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_board_ctrl #(.VERSION(VER), .SYNC(2)) i_spi_board_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .sw_i(sw_i), .pgood0_i(pgood0_i), .pgood1_i(pgood1_i), .pgood2_i(pgood2_i),
    .mstsel_i(mstsel_i), .led_o(led_o), .card_pwr_o(card_pwr_o),
    .cpu_rst_o(cpu_rst_o), .periph_rst_o(periph_rst_o), .sfp_a_o(sfp_a_o),
    .sfp_b_o(sfp_b_o), .warm_rst_o(warm_rst_o), .warm_key_o(warm_key_o),
    .pmbus_o(pmbus_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nb,
                      input logic flip, input logic [7:0] swn, output logic [7:0] rd);
    logic [15:0] f;
    f = {a, d};
    rd = 0;
    @(negedge clk);
    cs_n = 0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sclk = 0;
      mosi = (i < 16) ? f[15-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i >= 8 && i < 16) rd = {rd[6:0], miso};
      sclk = 1;
      if (flip && i == 15) sw_i = swn;
      repeat (HP) @(negedge clk);
    end
    cs_n = 1;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] unused;
    xfer(a, d, 16, 1'b0, 8'h00, unused);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] r;
    xfer(a, 8'h00, 16, 1'b0, 8'h00, r);
    chk(req, r, exp);
  endtask

  function automatic logic [7:0] ctl_out(input logic [7:0] a);
    case (a)
      8'h0E: return card_pwr_o;
      8'h10: return cpu_rst_o;
      8'h12: return periph_rst_o;
      8'h14: return sfp_a_o;
      8'h16: return sfp_b_o;
      8'h1A: return warm_rst_o;
      8'h1C: return warm_key_o;
      default: return pmbus_o;
    endcase
  endfunction

  task automatic t_reset;
    chk("R9 reset led", {4'h0, led_o}, 8'h00);
    chk("R9 reset card", card_pwr_o, 8'h00);
    chk("R9 reset pmbus", pmbus_o, 8'h00);
    chk("R7 reset irq", {7'h0, irq_o}, 8'h00);
    chk("R10 idle miso", {7'h0, miso}, 8'h00);
  endtask

  task automatic t_version;
    rd_chk("R4 version read", 8'h01, VER);
    wr(8'h00, 8'hFF);
    rd_chk("R4 write nop", 8'h01, VER);
    chk("R4 no side effect", card_pwr_o, 8'h00);
  endtask

  task automatic t_led;
    wr(8'h02, 8'hC3);
    chk("R5 led outputs", {4'h0, led_o}, 8'h0C);
    rd_chk("R5 R1 led readback", 8'h03, 8'hC3);
  endtask

  task automatic t_ctl;
    logic [7:0] addrs [8] = '{8'h0E, 8'h10, 8'h12, 8'h14, 8'h16, 8'h1A, 8'h1C, 8'h1E};
    for (int k = 0; k < 8; k++) wr(addrs[k], 8'h81 + 8'(k * 17));
    for (int k = 0; k < 8; k++) begin
      chk("R9 ctl output", ctl_out(addrs[k]), 8'h81 + 8'(k * 17));
      rd_chk("R9 R3 ctl readback", addrs[k] | 8'h01, 8'h81 + 8'(k * 17));
    end
  endtask

  task automatic t_switch_flags;
    logic [7:0] unused;
    sw_i = 8'h05;
    repeat (10) @(negedge clk);
    rd_chk("R6 switch read", 8'h05, 8'h05);
    wr(8'h04, 8'hFF);
    rd_chk("R6 switch write ignored", 8'h05, 8'h05);
    chk("R7 irq set", {7'h0, irq_o}, 8'h01);
    rd_chk("R7 flags set", 8'h07, 8'h05);
    wr(8'h06, 8'h01);
    rd_chk("R7 partial clear", 8'h07, 8'h04);
    xfer(8'h06, 8'hFF, 16, 1'b1, 8'h01, unused);
    rd_chk("R7 change beats clear", 8'h07, 8'h04);
    wr(8'h06, 8'h04);
    rd_chk("R7 all cleared", 8'h07, 8'h00);
    chk("R7 irq low", {7'h0, irq_o}, 8'h00);
  endtask

  task automatic t_status;
    pgood0_i = 8'h11; pgood1_i = 8'h22; pgood2_i = 8'h33; mstsel_i = 8'h44;
    repeat (10) @(negedge clk);
    rd_chk("R8 pgood0", 8'h09, 8'h11);
    rd_chk("R8 pgood1", 8'h0B, 8'h22);
    rd_chk("R8 pgood2", 8'h0D, 8'h33);
    rd_chk("R8 mstsel", 8'h19, 8'h44);
    wr(8'h08, 8'h00);
    wr(8'h18, 8'h00);
    rd_chk("R8 pgood0 write ignored", 8'h09, 8'h11);
    rd_chk("R8 mstsel write ignored", 8'h19, 8'h44);
  endtask

  task automatic t_unmapped;
    wr(8'h20, 8'hFF);
    wr(8'hFE, 8'hFF);
    rd_chk("R11 read 0x20", 8'h21, 8'h00);
    rd_chk("R11 read 0xFE", 8'hFF, 8'h00);
    chk("R11 card untouched", card_pwr_o, 8'h81);
    chk("R11 pmbus untouched", pmbus_o, 8'h81 + 8'(7 * 17));
    chk("R11 led untouched", {4'h0, led_o}, 8'h0C);
  endtask

  task automatic t_abort;
    logic [7:0] unused;
    wr(8'h0E, 8'h5A);
    xfer(8'h0E, 8'hFF, 12, 1'b0, 8'h00, unused);
    chk("R10 aborted write", card_pwr_o, 8'h5A);
    chk("R10 miso idle after abort", {7'h0, miso}, 8'h00);
    rd_chk("R10 readback after abort", 8'h0F, 8'h5A);
  endtask

  task automatic t_extra_clocks;
    logic [7:0] unused;
    xfer(8'h1E, 8'h3C, 20, 1'b0, 8'h00, unused);
    chk("R2 extra clocks", pmbus_o, 8'h3C);
    rd_chk("R2 fresh frame", 8'h1F, 8'h3C);
    rd_chk("R2 no auto increment", 8'h03, 8'hC3);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_version();
    t_led();
    t_ctl();
    t_switch_flags();
    t_status();
    t_unmapped();
    t_abort();
    t_extra_clocks();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end
endmodule